// File: doc/BRIEF.md
# ADC Sample Formatter and Source Selector

This block takes the 12-bit parallel output of an external pipelined converter, together with the converter's over-range flag, on every sample clock. It registers both, and when configured for a converter set to straight-binary coding it turns each code into two's complement by flipping the top bit. A select input picks either that stream or an internal test-tone stream that is already in two's complement. The chosen sample is placed in a 32-bit AXI4-Stream word. The low half carries the sign-extended sample and the over-range bit. The high half is zero and is kept free for a quadrature part that later stages will add.

The converter cannot be paused. If the downstream side holds off while the converter stream is selected, samples are lost and a sticky flag records the loss until reset. The test-tone stream does wait for the downstream side, through its own ready signal.

Top module: `adc_stream_formatter`

## Requirements
- R1: While reset is held, and at the first sample point after it, `m_tvalid` is 0, `overflow` is 0 and `m_tdata` is 0.
- R2: With `sel_tone`=0 and `cfg_offset_bin`=0, a converter code driven before clock edge k appears unchanged in `m_tdata[11:0]` after edge k+1. That is one input register plus one output register.
- R3: With `cfg_offset_bin`=1, bit 11 of the converter code is inverted and the other bits pass through, so 0xFFF becomes 0x7FF, 0x7FF becomes 0xFFF and 0x000 becomes 0x800.
- R4: In each output word, bits [11:0] hold the sample and bit 12 holds the over-range flag. Bits [15:13] copy bit 11 and bits [31:16] are 0.
- R5: With `sel_tone`=1, the tone sample goes to bits [11:0] with no conversion, whatever `cfg_offset_bin` is, and bit 12 is 0 whatever `adc_ovr` is.
- R6: `tone_tready` is 1 only when `sel_tone`=1 and the output slot is free, meaning `m_tvalid`=0 or `m_tready`=1. If no tone sample is offered, the slot empties and `m_tvalid` falls.
- R7: While `m_tvalid`=1 and `m_tready`=0, `m_tdata` and `m_tvalid` do not change.
- R8: When the converter stream is selected and a captured sample cannot enter the stalled output slot, `overflow` rises. It stays at 1 until reset.
- R9: A change of `sel_tone` during a stall leaves the held word untouched. The new source supplies the next word that is loaded.
- R10: With the converter stream selected and `m_tready`=1, `m_tvalid` stays 1 on every cycle after the first captured sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_offset_bin | input | 1 | 1: converter codes are straight binary and are converted |
| sel_tone | input | 1 | 1: test-tone stream, 0: converter stream |
| adc_data | input | 12 | Parallel converter code |
| adc_ovr | input | 1 | Converter over-range flag |
| tone_tdata | input | 12 | Test-tone sample, two's complement |
| tone_tvalid | input | 1 | Test-tone sample valid |
| tone_tready | output | 1 | Test-tone sample accepted |
| m_tdata | output | 32 | Packed output word |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Downstream ready |
| overflow | output | 1 | Sticky flag for lost converter samples |

## Verification
The assertions check on every cycle that a stalled word stays frozen (R7), that the loss flag never falls (R8), that an accepted tone sample arrives untouched with its over-range bit clear (R5), and that the converter path keeps the output valid (R10). Only the bench scenarios can show the code values of the conversion and the packing (R3, R4) and the exact two-edge latency (R2). The same holds for the loss flag rising on the first dropped sample, the source change during a stall (R9), and the flag clearing on reset.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
   typedef enum logic {
      SRC_ADC  = 1'b0,
      SRC_TONE = 1'b1
   } src_sel_e;
endpackage

// File: rtl/adc_capture_reg.sv
module adc_capture_reg #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic         d_ovr,
   output logic [W-1:0] q,
   output logic         q_ovr,
   output logic         q_valid
);
   // one fixed register stage on the converter clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q       <= '0;
         q_ovr   <= 1'b0;
         q_valid <= 1'b0;
      end else begin
         q       <= d;
         q_ovr   <= d_ovr;
         q_valid <= 1'b1;
      end
   end
endmodule

// File: rtl/adc_code_convert.sv
module adc_code_convert #(
   parameter int W          = 12,
   parameter bit CONVERT_EN = 1'b1
) (
   input  logic         offset_bin,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (CONVERT_EN) begin : g_conv
         // straight binary to two's complement: flip the sign position
         always_comb dout = {din[W-1] ^ offset_bin, din[W-2:0]};
      end else begin : g_pass
         logic unused_cfg;
         always_comb begin
            unused_cfg = offset_bin;
            dout       = din;
         end
      end
   endgenerate
endmodule

// File: rtl/sample_word_pack.sv
module sample_word_pack #(
   parameter int W      = 12,
   parameter int HALF_W = 16,
   parameter int WORD_W = 32
) (
   input  logic [W-1:0]      smp,
   input  logic              ovr,
   output logic [WORD_W-1:0] word
);
   localparam int EXT_W = HALF_W - W - 1;
   localparam int HI_W  = WORD_W - HALF_W;

   always_comb word = {{HI_W{1'b0}}, {EXT_W{smp[W-1]}}, ovr, smp};
endmodule

// File: rtl/src_stream_mux.sv
module src_stream_mux
   import adc_fmt_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_tone,
   input  logic [WORD_W-1:0] adc_word,
   input  logic              adc_valid,
   input  logic [WORD_W-1:0] tone_word,
   input  logic              tone_valid,
   output logic              tone_ready,
   output logic [WORD_W-1:0] out_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              lost
);
   src_sel_e src;
   logic     slot_free, take_adc, take_tone;

   always_comb begin
      src        = sel_tone ? SRC_TONE : SRC_ADC;
      slot_free  = !out_valid || out_ready;
      take_adc   = slot_free && (src == SRC_ADC) && adc_valid;
      take_tone  = slot_free && (src == SRC_TONE) && tone_valid;
      tone_ready = slot_free && (src == SRC_TONE);
   end

   // source is chosen only when a whole new word is loaded
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
      end else if (take_adc) begin
         out_data  <= adc_word;
         out_valid <= 1'b1;
      end else if (take_tone) begin
         out_data  <= tone_word;
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lost <= 1'b0;
      else if (!slot_free && (src == SRC_ADC) && adc_valid)
         lost <= 1'b1;
   end

   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   p_sticky_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lost |=> lost);

   p_adc_continuous_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_tone && adc_valid) |=> out_valid);
endmodule

// File: rtl/adc_stream_formatter.sv
module adc_stream_formatter #(
   parameter int SAMPLE_W   = 12,
   parameter int HALF_W     = 16,
   parameter int WORD_W     = 32,
   parameter bit CONVERT_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_offset_bin,
   input  logic                sel_tone,
   input  logic [SAMPLE_W-1:0] adc_data,
   input  logic                adc_ovr,
   input  logic [SAMPLE_W-1:0] tone_tdata,
   input  logic                tone_tvalid,
   output logic                tone_tready,
   output logic [WORD_W-1:0]   m_tdata,
   output logic                m_tvalid,
   input  logic                m_tready,
   output logic                overflow
);
   generate
      if (HALF_W < SAMPLE_W + 2 || WORD_W != 2 * HALF_W || SAMPLE_W < 2) begin : g_bad_cfg
         $error("adc_stream_formatter: width parameters inconsistent");
      end
   endgenerate

   logic [SAMPLE_W-1:0] cap_q, cap_conv;
   logic                cap_ovr, cap_valid;
   logic [WORD_W-1:0]   adc_word, tone_word;

   adc_capture_reg #(.W(SAMPLE_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .d(adc_data), .d_ovr(adc_ovr),
      .q(cap_q), .q_ovr(cap_ovr), .q_valid(cap_valid)
   );

   adc_code_convert #(.W(SAMPLE_W), .CONVERT_EN(CONVERT_EN)) u_conv (
      .offset_bin(cfg_offset_bin), .din(cap_q), .dout(cap_conv)
   );

   sample_word_pack #(.W(SAMPLE_W), .HALF_W(HALF_W), .WORD_W(WORD_W)) u_pack_adc (
      .smp(cap_conv), .ovr(cap_ovr), .word(adc_word)
   );

   // tone samples carry no over-range information
   sample_word_pack #(.W(SAMPLE_W), .HALF_W(HALF_W), .WORD_W(WORD_W)) u_pack_tone (
      .smp(tone_tdata), .ovr(1'b0), .word(tone_word)
   );

   src_stream_mux #(.WORD_W(WORD_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .sel_tone(sel_tone),
      .adc_word(adc_word), .adc_valid(cap_valid),
      .tone_word(tone_word), .tone_valid(tone_tvalid), .tone_ready(tone_tready),
      .out_data(m_tdata), .out_valid(m_tvalid), .out_ready(m_tready),
      .lost(overflow)
   );

   p_tone_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_tvalid && tone_tready) |=>
         (!m_tdata[SAMPLE_W] && m_tdata[SAMPLE_W-1:0] == $past(tone_tdata)));
endmodule

// File: tb/sim_adc_stream_formatter.sv
module sim_adc_stream_formatter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_offset_bin, sel_tone, adc_ovr, tone_tvalid, m_tready;
   logic [11:0] adc_data, tone_tdata;
   logic        tone_tready, m_tvalid, overflow;
   logic [31:0] m_tdata;
   int          checks = 0;
   int          failures = 0;

   always #10 clk = ~clk;

   adc_stream_formatter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_offset_bin(cfg_offset_bin), .sel_tone(sel_tone),
      .adc_data(adc_data), .adc_ovr(adc_ovr), .tone_tdata(tone_tdata),
      .tone_tvalid(tone_tvalid), .tone_tready(tone_tready), .m_tdata(m_tdata),
      .m_tvalid(m_tvalid), .m_tready(m_tready), .overflow(overflow)
   );

   // {offset_bin, code, ovr, expected word}
   localparam logic [45:0] VEC [8] = '{
      {1'b0, 12'h7FF, 1'b0, 32'h0000_07FF},
      {1'b0, 12'h800, 1'b0, 32'h0000_E800},
      {1'b1, 12'hFFF, 1'b0, 32'h0000_07FF},
      {1'b1, 12'h7FF, 1'b0, 32'h0000_EFFF},
      {1'b1, 12'h000, 1'b0, 32'h0000_E800},
      {1'b0, 12'h123, 1'b1, 32'h0000_1123},
      {1'b1, 12'hABC, 1'b1, 32'h0000_12BC},
      {1'b0, 12'hFFF, 1'b1, 32'h0000_FFFF}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_offset_bin = 1'b0; sel_tone = 1'b0; adc_ovr = 1'b0;
      adc_data = '0; tone_tdata = '0; tone_tvalid = 1'b0; m_tready = 1'b1;
      tick(2);
      chk("R1 valid in reset", {31'b0, m_tvalid}, 32'd0);
      chk("R1 data in reset", m_tdata, 32'd0);
      chk("R1 overflow in reset", {31'b0, overflow}, 32'd0);
      rst_n = 1'b1;
      #1;
      chk("R1 valid after reset", {31'b0, m_tvalid}, 32'd0);

      // R2 R3 R4 R10: converter path vectors
      foreach (VEC[i]) begin
         @(negedge clk);
         cfg_offset_bin = VEC[i][45];
         adc_data       = VEC[i][44:33];
         adc_ovr        = VEC[i][32];
         tick(2);
         chk($sformatf("R2/R3/R4 vector %0d", i), m_tdata, VEC[i][31:0]);
         chk("R10 valid held", {31'b0, m_tvalid}, 32'd1);
      end
      chk("R8 no loss with ready", {31'b0, overflow}, 32'd0);

      // R5: tone path, no conversion, over-range bit clear
      @(negedge clk);
      sel_tone = 1'b1; cfg_offset_bin = 1'b1; adc_ovr = 1'b1;
      tone_tdata = 12'h7FF; tone_tvalid = 1'b1;
      #1;
      chk("R6 tone ready when free", {31'b0, tone_tready}, 32'd1);
      tick(1);
      chk("R5 tone positive", m_tdata, 32'h0000_07FF);
      @(negedge clk);
      tone_tdata = 12'h800;
      tick(1);
      chk("R5 tone negative", m_tdata, 32'h0000_E800);
      @(negedge clk);
      tone_tvalid = 1'b0;
      tick(1);
      chk("R6 no tone offered", {31'b0, m_tvalid}, 32'd0);

      // R6 R7: tone stall
      @(negedge clk);
      tone_tdata = 12'h321; tone_tvalid = 1'b1; m_tready = 1'b0;
      tick(1);
      chk("R6 tone loaded", m_tdata, 32'h0000_0321);
      chk("R6 tone ready low in stall", {31'b0, tone_tready}, 32'd0);
      @(negedge clk);
      tone_tdata = 12'h456;
      tick(1);
      chk("R7 tone word held", m_tdata, 32'h0000_0321);
      @(negedge clk);
      m_tready = 1'b1;
      tick(1);
      chk("R6 next tone after release", m_tdata, 32'h0000_0456);
      chk("R8 no loss in tone mode", {31'b0, overflow}, 32'd0);

      // R7 R8: converter stall drops samples
      @(negedge clk);
      tone_tvalid = 1'b0; sel_tone = 1'b0; cfg_offset_bin = 1'b0; adc_ovr = 1'b0;
      adc_data = 12'h100;
      tick(2);
      chk("R2 converter word", m_tdata, 32'h0000_0100);
      @(negedge clk);
      m_tready = 1'b0; adc_data = 12'h200;
      tick(1);
      chk("R8 loss flagged", {31'b0, overflow}, 32'd1);
      chk("R7 word held", m_tdata, 32'h0000_0100);
      tick(2);
      chk("R7 word still held", m_tdata, 32'h0000_0100);
      chk("R7 valid held", {31'b0, m_tvalid}, 32'd1);

      // R9: switch source during stall
      @(negedge clk);
      sel_tone = 1'b1; tone_tdata = 12'h055; tone_tvalid = 1'b1;
      tick(1);
      chk("R9 held word unchanged", m_tdata, 32'h0000_0100);
      chk("R9 tone waits", {31'b0, tone_tready}, 32'd0);
      @(negedge clk);
      m_tready = 1'b1;
      tick(1);
      chk("R9 new source on next word", m_tdata, 32'h0000_0055);
      @(negedge clk);
      sel_tone = 1'b0; tone_tvalid = 1'b0;
      tick(2);
      chk("R9 back to converter", m_tdata, 32'h0000_0200);
      chk("R8 flag sticky", {31'b0, overflow}, 32'd1);

      // R8: reset clears the flag
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R8 flag cleared by reset", {31'b0, overflow}, 32'd0);
      chk("R1 valid cleared by reset", {31'b0, m_tvalid}, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule